// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a management-interface master that software drives through a single 32-bit command register. The host writes the target PHY address, the PHY register address, the direction and, for writes, a 16-bit payload. It also sets a start flag. The engine waits for the next rising edge of its internally divided management clock. It then serializes a complete management frame onto the MDIO line. For a read, it collects the sixteen returned bits and records whether the PHY pulled the line low in the second turnaround slot. When the frame has finished, it clears the start flag.

The management clock is a divided copy of the system clock. The master moves MDIO one system cycle after each management-clock rise and samples the returned line on the rise itself, so the PHY sees stable data on every rising edge. While a transaction is in flight, the command register is frozen. An enable input decides whether a start request is accepted at all.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command register reads as all zeros, MDIO output enable is low and MDC is low.
- R2: The command register layout is: start flag at bit 31, direction at bit 30 (1 = PHY write, 0 = PHY read), acknowledge flag at bit 29, zeros at bits 28:26, register address at bits 25:21, PHY address at bits 20:16 and data at bits 15:0. Bits 29:26 ignore host writes.
- R3: A write frame is sent MSB first as 32 ones, then 01, then opcode 01, then PHY address, then register address, then turnaround 10, then the 16 data bits, with output enable high for all 64 bits.
- R4: A read frame carries opcode 10, keeps output enable high for bits 0 to 45 only, and stores the 16 bits sampled in slots 48 to 63 (MSB first) into the data field.
- R5: On a read, the acknowledge flag becomes 1 if MDIO is low in slot 47 and 0 otherwise. The data field is updated either way.
- R6: The start flag reads 1 right after it is set. It clears only after the last of the 64 bits has been sent, and output enable is never high while the flag is 0.
- R7: While the start flag is 1, every host write to the command register is discarded.
- R8: A write that sets the start flag while the enable input is low updates the other fields but leaves the flag at 0, and no frame is sent.
- R9: A write with bit 31 at 0 updates the fields and starts no transaction.
- R10: The acknowledge flag returns to 0 once a new transaction has been accepted.
- R11: MDC has a period of 2*MDC_HALF system cycles. MDIO out changes only in the system cycle right after an MDC rising edge.
- R12: Accesses to any bus address other than CMD_ADDR read as zero and have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enIn | input | 1 | Engine enable; gates acceptance of the start flag |
| busAddr | input | ADDR_W | Register bus address |
| busWe | input | 1 | Register bus write strobe |
| busWdata | input | 32 | Register bus write data |
| busRdata | output | 32 | Register bus read data (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value driven by the master |
| mdioOe | output | 1 | MDIO output enable (1 = master drives) |
| mdioIn | input | 1 | MDIO value observed on the pin |

## Verification
The hardest situation to reach is a host write that lands while a frame is already on the wire. It has to arrive after the start flag has been accepted and the acknowledge flag has been cleared, but before the last bit. The bench polls the output enable until the frame has visibly begun. Only then does it issue the conflicting write, and afterwards it checks both the register readback and the data bits that actually went out. A bench PHY model that can withhold the acknowledge and leave the line floating covers the read path without acknowledge, where all-ones data must still be stored.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int FRAME_LEN = 64;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int DATA_W    = 16;
  localparam int ADR_W     = 5;
  localparam int CMD_W     = 32;

  localparam logic [IDX_W-1:0] LAST_IDX     = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] DATA_IDX     = IDX_W'(FRAME_LEN - DATA_W);
  localparam logic [IDX_W-1:0] TA2_IDX      = IDX_W'(FRAME_LEN - DATA_W - 1);
  localparam logic [IDX_W-1:0] ADR_LAST_IDX = IDX_W'(FRAME_LEN - DATA_W - 3);

  typedef struct packed {
    logic load;
    logic advance;
    logic capture;
    logic ackSample;
    logic done;
  } engStrobe_t;

  function automatic logic [FRAME_LEN-1:0] buildFrame(
    input logic              isWr,
    input logic [ADR_W-1:0]  phyA,
    input logic [ADR_W-1:0]  regA,
    input logic [DATA_W-1:0] dat
  );
    logic [1:0] opc;
    logic [1:0] ta;
    logic [DATA_W-1:0] payload;
    opc     = isWr ? 2'b01 : 2'b10;
    ta      = isWr ? 2'b10 : 2'b11;
    payload = isWr ? dat : '1;
    return {{32{1'b1}}, 2'b01, opc, phyA, regA, ta, payload};
  endfunction
endpackage

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_cmd_pkg::*;
#(
  parameter int MDC_HALF = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       goFlag,
  input  logic       isWrite,
  output engStrobe_t stb,
  output logic       mdc,
  output logic       mdioOe,
  output logic       frameActive
);
  localparam int DIV_W = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

  logic [DIV_W-1:0] divCnt;
  logic             halfEnd;
  logic             riseTick;
  logic             riseDly;
  logic [IDX_W-1:0] bitIdx;
  logic             lastBit;

  assign halfEnd  = (divCnt == DIV_W'(MDC_HALF - 1));
  assign riseTick = halfEnd && !mdc;
  assign lastBit  = (bitIdx == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      mdc     <= 1'b0;
      riseDly <= 1'b0;
    end else begin
      riseDly <= riseTick;
      if (halfEnd) begin
        divCnt <= '0;
        mdc    <= ~mdc;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb           = '0;
    stb.load      = riseDly && !frameActive && goFlag;
    stb.advance   = riseDly && frameActive && !lastBit;
    stb.done      = riseDly && frameActive && lastBit;
    stb.capture   = riseTick && frameActive && (bitIdx >= DATA_IDX);
    stb.ackSample = riseTick && frameActive && (bitIdx == TA2_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameActive <= 1'b0;
      bitIdx      <= '0;
      mdioOe      <= 1'b0;
    end else if (stb.load) begin
      frameActive <= 1'b1;
      bitIdx      <= '0;
      mdioOe      <= 1'b1;
    end else if (stb.advance) begin
      bitIdx <= bitIdx + 1'b1;
      mdioOe <= isWrite || (bitIdx < ADR_LAST_IDX);
    end else if (stb.done) begin
      frameActive <= 1'b0;
      bitIdx      <= '0;
      mdioOe      <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_cmd_dp.sv
module mdio_cmd_dp
  import mdio_cmd_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CMD_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [CMD_W-1:0]  busWdata,
  output logic [CMD_W-1:0]  busRdata,
  input  engStrobe_t        stb,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              goFlag,
  output logic              isWrite,
  output logic [1+2*ADR_W+DATA_W-1:0] cmdFields
);
  logic                 busHit;
  logic                 ackBit;
  logic                 ackTmp;
  logic [ADR_W-1:0]     regAdr;
  logic [ADR_W-1:0]     phyAdr;
  logic [DATA_W-1:0]    dataF;
  logic [DATA_W-1:0]    rdShift;
  logic [FRAME_LEN-1:0] shiftReg;
  logic                 unusedWdata;

  assign unusedWdata = ^busWdata[29:26];
  assign busHit      = (busAddr == ADDR_W'(CMD_ADDR));
  assign busRdata    = busHit ? {goFlag, isWrite, ackBit, 3'b000, regAdr, phyAdr, dataF} : '0;
  assign mdioOut     = shiftReg[FRAME_LEN-1];
  assign cmdFields   = {isWrite, regAdr, phyAdr, dataF};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goFlag   <= 1'b0;
      isWrite  <= 1'b0;
      ackBit   <= 1'b0;
      ackTmp   <= 1'b0;
      regAdr   <= '0;
      phyAdr   <= '0;
      dataF    <= '0;
      rdShift  <= '0;
      shiftReg <= '0;
    end else begin
      if (busHit && busWe && !goFlag) begin
        isWrite <= busWdata[30];
        regAdr  <= busWdata[25:21];
        phyAdr  <= busWdata[20:16];
        dataF   <= busWdata[15:0];
        goFlag  <= busWdata[31] && enIn;
      end
      if (stb.load) begin
        shiftReg <= buildFrame(isWrite, phyAdr, regAdr, dataF);
        ackBit   <= 1'b0;
        ackTmp   <= 1'b0;
        rdShift  <= '0;
      end else if (stb.advance) begin
        shiftReg <= {shiftReg[FRAME_LEN-2:0], 1'b1};
      end
      if (stb.capture) begin
        rdShift <= {rdShift[DATA_W-2:0], mdioIn};
      end
      if (stb.ackSample) begin
        ackTmp <= !mdioIn;
      end
      if (stb.done) begin
        goFlag <= 1'b0;
        if (!isWrite) begin
          dataF  <= rdShift;
          ackBit <= ackTmp;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_cmd_pkg::*;
#(
  parameter int MDC_HALF = 2,
  parameter int ADDR_W   = 4,
  parameter int CMD_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  engStrobe_t stb;
  logic       goFlag;
  logic       isWrite;
  logic       frameActive;
  logic [1+2*ADR_W+DATA_W-1:0] cmdFields;

  mdio_cmd_ctrl #(.MDC_HALF(MDC_HALF)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .goFlag      (goFlag),
    .isWrite     (isWrite),
    .stb         (stb),
    .mdc         (mdc),
    .mdioOe      (mdioOe),
    .frameActive (frameActive)
  );

  mdio_cmd_dp #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .enIn      (enIn),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .stb       (stb),
    .mdioIn    (mdioIn),
    .mdioOut   (mdioOut),
    .goFlag    (goFlag),
    .isWrite   (isWrite),
    .cmdFields (cmdFields)
  );
endmodule

// File: rtl/mdio_cmd_checker.sv
module mdio_cmd_checker (
  input logic        clk,
  input logic        rstN,
  input logic        enIn,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe,
  input logic        goFlag,
  input logic        frameActive,
  input logic [26:0] cmdFields
);
  AST_OE_NEEDS_GO: assert property (@(posedge clk) disable iff (!rstN)
    mdioOe |-> goFlag); // R6

  AST_GO_CLEARS_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $fell(goFlag) |-> $past(frameActive)); // R6

  AST_GO_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(goFlag) |-> $past(enIn)); // R8

  AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (goFlag && $past(goFlag)) |-> $stable(cmdFields)); // R7

  AST_MDIO_AFTER_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdioOut) |-> ($past(mdc) && !$past(mdc, 2))); // R11
endmodule

bind mdio_cmd_engine mdio_cmd_checker uChk (
  .clk         (clk),
  .rstN        (rstN),
  .enIn        (enIn),
  .mdc         (mdc),
  .mdioOut     (mdioOut),
  .mdioOe      (mdioOe),
  .goFlag      (goFlag),
  .frameActive (frameActive),
  .cmdFields   (cmdFields)
);

// File: tb/tb_mdio_cmd_engine.sv
`timescale 1ns/1ps
module tb_mdio_cmd_engine;
  localparam int MDC_HALF = 2;
  localparam int ADDR_W   = 4;
  localparam logic [ADDR_W-1:0] CMD = 4'd0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enIn = 1'b1;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic mdc, mdioOut, mdioOe, mdioIn;

  always #2 clk = ~clk;

  mdio_cmd_engine #(.MDC_HALF(MDC_HALF), .ADDR_W(ADDR_W), .CMD_ADDR(0)) dut (
    .clk(clk), .rstN(rstN), .enIn(enIn), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  // PHY model state
  logic phyDrv = 1'b0, phyVal = 1'b1;
  bit phyAck = 0, phyDriveData = 0;
  logic [15:0] phyData = '0;
  logic [63:0] obsBits = '0, obsOe = '0;
  bit inFrame = 0, isRd = 0;
  int n = 0, framesDone = 0, oeSeen = 0, badChange = 0;
  int cyc = 0, lastRise = 0, riseGap = 0;
  logic prevMdc = 1'b0, prevOut = 1'b0;
  bit riseLast = 0;

  assign mdioIn = mdioOe ? mdioOut : (phyDrv ? phyVal : 1'b1);

  always @(negedge clk) begin
    bit riseNow;
    int nxt;
    cyc++;
    if (mdioOe) oeSeen++;
    if (rstN && (mdioOut !== prevOut) && !riseLast) badChange++;
    prevOut = mdioOut;
    riseNow = mdc && !prevMdc;
    prevMdc = mdc;
    if (riseNow) begin
      riseGap = cyc - lastRise;
      lastRise = cyc;
      if (!inFrame && mdioOe) begin
        inFrame = 1; n = 0; isRd = 0;
      end else if (inFrame) begin
        n++;
      end
      if (inFrame) begin
        obsBits[63-n] = mdioOut;
        obsOe[63-n] = mdioOe;
        if (n == 35) isRd = obsBits[63-34] && !obsBits[63-35];
        nxt = n + 1;
        phyDrv = 1'b0;
        if (isRd && nxt == 47 && phyAck) begin phyDrv = 1'b1; phyVal = 1'b0; end
        if (isRd && nxt >= 48 && nxt <= 63 && phyDriveData) begin
          phyDrv = 1'b1; phyVal = phyData[63-nxt];
        end
        if (n == 63) begin inFrame = 0; framesDone++; phyDrv = 1'b0; end
      end
    end
    riseLast = riseNow;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(bit go, bit wr, logic [4:0] ra, logic [4:0] pa, logic [15:0] d);
    return {go, wr, 1'b0, 3'b000, ra, pa, d};
  endfunction

  function automatic logic [63:0] expFrame(bit wr, logic [4:0] pa, logic [4:0] ra, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), pa, ra, 2'b10, d};
  endfunction

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busAddr = CMD;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
    busAddr = CMD;
  endtask

  task automatic waitIdle(input string req);
    logic [31:0] r;
    bit idle = 0;
    for (int i = 0; i < 3000 && !idle; i++) begin
      busRead(CMD, r);
      idle = !r[31];
    end
    chk(idle, req, "start flag never cleared", {63'd0, !idle}, 64'd0);
  endtask

  task automatic tReset();
    logic [31:0] r;
    busRead(CMD, r);
    chk(r == 32'd0, "R1", "register after reset", r, 0);
    chk(mdioOe == 1'b0 && mdc == 1'b0, "R1", "oe/mdc after reset", {mdioOe, mdc}, 0);
  endtask

  task automatic tLayout();
    logic [31:0] r;
    int oe0;
    busWrite(CMD, 32'h7C00_0000 | mkCmd(0, 0, 5'h15, 5'h0B, 16'hBEEF));
    busRead(CMD, r);
    chk(r == mkCmd(0, 1, 5'h15, 5'h0B, 16'hBEEF), "R2", "field layout", r, mkCmd(0, 1, 5'h15, 5'h0B, 16'hBEEF));
    busRead(4'd3, r);
    chk(r == 32'd0, "R12", "other address read", r, 0);
    oe0 = oeSeen;
    busWrite(4'd5, mkCmd(1, 0, 5'h01, 5'h02, 16'h1111));
    repeat (300) @(negedge clk);
    busRead(CMD, r);
    chk(r == mkCmd(0, 1, 5'h15, 5'h0B, 16'hBEEF), "R12", "other address write", r, mkCmd(0, 1, 5'h15, 5'h0B, 16'hBEEF));
    chk(oeSeen == oe0, "R12", "no frame from other address", oeSeen, oe0);
  endtask

  task automatic tGoZero();
    logic [31:0] r;
    int oe0 = oeSeen;
    busWrite(CMD, mkCmd(0, 1, 5'h03, 5'h04, 16'h5A5A));
    busRead(CMD, r);
    chk(r == mkCmd(0, 1, 5'h03, 5'h04, 16'h5A5A), "R9", "fields without start", r, mkCmd(0, 1, 5'h03, 5'h04, 16'h5A5A));
    repeat (400) @(negedge clk);
    chk(oeSeen == oe0, "R9", "no frame without start", oeSeen, oe0);
  endtask

  task automatic tDisabled();
    logic [31:0] r;
    int oe0;
    enIn = 1'b0;
    oe0 = oeSeen;
    busWrite(CMD, mkCmd(1, 0, 5'h06, 5'h07, 16'h0F0F));
    busRead(CMD, r);
    chk(r == mkCmd(0, 0, 5'h06, 5'h07, 16'h0F0F), "R8", "start ignored when disabled", r, mkCmd(0, 0, 5'h06, 5'h07, 16'h0F0F));
    repeat (400) @(negedge clk);
    chk(oeSeen == oe0, "R8", "no frame when disabled", oeSeen, oe0);
    enIn = 1'b1;
  endtask

  task automatic tWriteFrame();
    logic [31:0] r;
    int f0 = framesDone;
    busWrite(CMD, mkCmd(1, 1, 5'h0A, 5'h13, 16'hA55C));
    busRead(CMD, r);
    chk(r[31] == 1'b1, "R6", "start flag set after write", r, 32'h8000_0000);
    waitIdle("R6");
    chk(framesDone == f0 + 1, "R6", "frame complete at flag clear", framesDone, f0 + 1);
    chk(obsBits == expFrame(1, 5'h13, 5'h0A, 16'hA55C), "R3", "write frame bits", obsBits, expFrame(1, 5'h13, 5'h0A, 16'hA55C));
    chk(obsOe == 64'hFFFF_FFFF_FFFF_FFFF, "R3", "write frame enable", obsOe, 64'hFFFF_FFFF_FFFF_FFFF);
    busRead(CMD, r);
    chk(r == mkCmd(0, 1, 5'h0A, 5'h13, 16'hA55C), "R6", "register after write", r, mkCmd(0, 1, 5'h0A, 5'h13, 16'hA55C));
    chk(riseGap == 2 * MDC_HALF, "R11", "MDC period", riseGap, 2 * MDC_HALF);
    chk(badChange == 0, "R11", "MDIO changes away from rise", badChange, 0);
  endtask

  task automatic tReadAck();
    logic [31:0] r;
    phyAck = 1; phyDriveData = 1; phyData = 16'h3C96;
    busWrite(CMD, mkCmd(1, 0, 5'h02, 5'h01, 16'h0000));
    waitIdle("R4");
    chk(obsBits[63:18] == expFrame(0, 5'h01, 5'h02, 16'h0)[63:18], "R4", "read header bits", obsBits[63:18], expFrame(0, 5'h01, 5'h02, 16'h0)[63:18]);
    chk(obsOe == {46'h3FFF_FFFF_FFFF, 18'h0}, "R4", "read enable window", obsOe, {46'h3FFF_FFFF_FFFF, 18'h0});
    busRead(CMD, r);
    chk(r == (mkCmd(0, 0, 5'h02, 5'h01, 16'h3C96) | 32'h2000_0000), "R5", "read data with ack", r, mkCmd(0, 0, 5'h02, 5'h01, 16'h3C96) | 32'h2000_0000);
  endtask

  task automatic tBusy();
    logic [31:0] r;
    bit seen = 0;
    phyAck = 0; phyDriveData = 0;
    busWrite(CMD, mkCmd(1, 1, 5'h09, 5'h07, 16'h1234));
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge clk);
      seen = mdioOe;
    end
    busRead(CMD, r);
    chk(r == mkCmd(1, 1, 5'h09, 5'h07, 16'h1234), "R10", "ack cleared once accepted", r, mkCmd(1, 1, 5'h09, 5'h07, 16'h1234));
    busWrite(CMD, mkCmd(1, 0, 5'h1F, 5'h1E, 16'hDEAD));
    busRead(CMD, r);
    chk(r == mkCmd(1, 1, 5'h09, 5'h07, 16'h1234), "R7", "write while busy discarded", r, mkCmd(1, 1, 5'h09, 5'h07, 16'h1234));
    waitIdle("R7");
    chk(obsBits == expFrame(1, 5'h07, 5'h09, 16'h1234), "R7", "frame unaffected by busy write", obsBits, expFrame(1, 5'h07, 5'h09, 16'h1234));
  endtask

  task automatic tReadNoAck();
    logic [31:0] r;
    phyAck = 0; phyDriveData = 0;
    busWrite(CMD, mkCmd(1, 0, 5'h11, 5'h12, 16'h0000));
    waitIdle("R5");
    busRead(CMD, r);
    chk(r == mkCmd(0, 0, 5'h11, 5'h12, 16'hFFFF), "R5", "read without ack", r, mkCmd(0, 0, 5'h11, 5'h12, 16'hFFFF));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tLayout();
    tGoZero();
    tDisabled();
    tWriteFrame();
    tReadAck();
    tBusy();
    tReadNoAck();
    summary();
  end
endmodule